// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block drives one eight-input converter that sits behind a single analog multiplexer. Two requesters share it. Each requester raises a request together with a channel-enable mask. A fixed-priority arbiter picks one request while the sequencer is idle. The sequencer then converts every enabled channel in rising index order, whatever order the requester had in mind. Each real result is returned with its channel index, its data and the number of the port that asked for it.

The converter needs time to settle when the multiplexer pattern changes. For this reason the sequencer keeps a copy of the last channel mask it executed. When a granted mask differs from that copy, or no copy exists yet after reset, the sequencer first runs two setup conversions on the first enabled channel. Their results are discarded. A request whose mask matches the stored copy starts with real conversions at once.

Every conversion occupies a fixed slot of `SLOT_CYCLES` clocks, 80 by default. The converter is driven through a one-cycle convert pulse and answers with a one-cycle done pulse that carries the result.

The controller has five states:
- `ST_IDLE` waits for a request. It goes to `ST_SETUP` when the granted mask needs setup, and to `ST_CONV` otherwise.
- `ST_SETUP` counts down the setup slots and then goes to `ST_CONV`.
- `ST_CONV` moves to the next enabled channel at each slot end. After the last enabled channel it goes to `ST_FLUSH`.
- `ST_FLUSH` is the cycle in which the final sample is presented. It always goes to `ST_DONE`.
- `ST_DONE` raises the end-of-scan pulse and returns to `ST_IDLE`.

Top module: `adc_scan_seq`

## Requirements
- R1: Enabled channels are converted in ascending index order, with exactly one real conversion per enabled channel. `adc_channel` shows the channel being converted whenever `adc_convert` is high.
- R2: Each real result appears for exactly one cycle on `smp_valid`. It carries its 3-bit channel index on `smp_chan`, the converter data on `smp_data` and the requester number on `smp_port`. It appears in the first cycle after its slot ends.
- R3: After reset no mask is stored. The first scan therefore begins with two setup conversions on its lowest enabled channel, and the results of those conversions never reach `smp_valid`. A scan of N channels with setup takes 80·(N+2)+2 cycles from the grant cycle to the end-of-scan cycle.
- R4: A granted mask equal to the stored mask skips setup, even when the other port supplied the stored mask. The scan then takes 80·N+2 cycles from grant to end of scan.
- R5: A granted mask that differs from the stored mask runs two setup conversions again. Every grant replaces the stored mask.
- R6: Each slot is exactly 80 cycles when the converter answers within the slot. `adc_convert` pulses for one cycle at the start of each slot. A full eight-channel scan without setup takes 642 cycles from grant to end of scan.
- R7: Grants follow a fixed priority in which port 0 beats port 1. A grant (`req_grant`, bit = port) is high for one cycle, during the idle cycle in which the request is taken. A request whose mask is all zero is never granted and starts no conversion.
- R8: A running scan is never pre-empted. `req_busy` of the owning port is high from the cycle after its grant through its end-of-scan cycle. A waiting request is granted in the cycle right after that end-of-scan cycle.
- R9: `scan_done` is high for one cycle, in the cycle after the last real sample. `done_port` gives the owning port in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request level per port, dropped after its grant |
| req_mask | input | NUM_PORTS*NUM_CH | Channel-enable mask per port, port p in bits p*NUM_CH upward |
| req_grant | output | NUM_PORTS | One-cycle grant, bit = port |
| req_busy | output | NUM_PORTS | Port owns the converter |
| adc_convert | output | 1 | Start-conversion pulse to the converter |
| adc_channel | output | 3 | Multiplexer channel select |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | DATA_W | Conversion result |
| smp_valid | output | 1 | Real sample strobe |
| smp_chan | output | 3 | Channel of the sample |
| smp_data | output | DATA_W | Sample data |
| smp_port | output | 1 | Requester owning the sample |
| scan_done | output | 1 | End-of-scan pulse |
| done_port | output | 1 | Requester whose scan ended |

## Verification
The hardest situations to reach from the ports are these:
- A mask whose setup is skipped because the *other* requester left it behind.
- A high-priority request that arrives in the middle of a low-priority scan and has to wait its turn.

The stimulus reaches the first by repeating one mask from port 0 and then from port 1. It reaches the second by starting a port-1 scan and raising port 0 one hundred cycles later, and by raising both ports in the same cycle. A behavioural stand-in converter returns its own running conversion count in every result. This means any setup result that leaks out, and any slot that is skipped, shows up as wrong data against the bench's reference timeline.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONV,
        ST_FLUSH,
        ST_DONE
    } scan_state_e;

    function automatic int unsigned bits_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/scan_arbiter.sv
module scan_arbiter #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_CH    = 8,
    localparam int PW       = adc_scan_pkg::bits_for(NUM_PORTS)
) (
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS*NUM_CH-1:0] req_mask,
    input  logic                        enable,
    output logic [NUM_PORTS-1:0]        grant,
    output logic                        any,
    output logic [PW-1:0]               win_port,
    output logic [NUM_CH-1:0]           win_mask
);

    logic [NUM_PORTS-1:0] eligible;

    // A request only counts when at least one channel is enabled.
    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_elig
            assign eligible[gp] = req_valid[gp] && (|req_mask[gp*NUM_CH +: NUM_CH]);
        end
    endgenerate

    // Fixed priority: the lowest port index wins.
    always_comb begin
        grant    = '0;
        win_port = '0;
        win_mask = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win_port = PW'(i);
                win_mask = req_mask[i*NUM_CH +: NUM_CH];
            end
        end
        any = enable && (|eligible);
        if (any) begin
            grant[win_port] = 1'b1;
        end
    end

endmodule

// File: rtl/chan_picker.sv
module chan_picker #(
    parameter int NUM_CH = 8,
    localparam int CW    = adc_scan_pkg::bits_for(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CW:0]       from_idx,
    output logic              found,
    output logic [CW-1:0]     idx
);

    // Lowest enabled channel whose index is at least from_idx.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && ((CW+1)'(i) >= from_idx)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_CYCLES = 80,
    localparam int TW         = adc_scan_pkg::bits_for(SLOT_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic adc_done,
    output logic slot_first,
    output logic slot_end
);

    localparam logic [TW-1:0] LAST = TW'(SLOT_CYCLES - 1);

    logic [TW-1:0] tick_q;
    logic          seen_q;

    // A slot ends at its last cycle, and only once the converter has answered.
    assign slot_first = run && (tick_q == '0);
    assign slot_end   = run && (tick_q == LAST) && (seen_q || adc_done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            seen_q <= 1'b0;
        end else if (!run || slot_end) begin
            tick_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (tick_q != LAST) begin
                tick_q <= tick_q + 1'b1;
            end
            if (adc_done) begin
                seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/list_tracker.sv
module list_tracker #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_CH-1:0] mask,
    output logic              needs_setup
);

    logic [NUM_CH-1:0] stored_q;
    logic              valid_q;

    assign needs_setup = !valid_q || (mask != stored_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= '0;
            valid_q  <= 1'b0;
        end else if (load) begin
            stored_q <= mask;
            valid_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int NUM_CH      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int DATA_W      = 12,
    parameter int SLOT_CYCLES = 80,
    parameter int SETUP_CONV  = 2,
    localparam int CW         = adc_scan_pkg::bits_for(NUM_CH),
    localparam int PW         = adc_scan_pkg::bits_for(NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS*NUM_CH-1:0] req_mask,
    output logic [NUM_PORTS-1:0]        req_grant,
    output logic [NUM_PORTS-1:0]        req_busy,
    output logic                        adc_convert,
    output logic [CW-1:0]               adc_channel,
    input  logic                        adc_done,
    input  logic [DATA_W-1:0]           adc_data,
    output logic                        smp_valid,
    output logic [CW-1:0]               smp_chan,
    output logic [DATA_W-1:0]           smp_data,
    output logic [PW-1:0]               smp_port,
    output logic                        scan_done,
    output logic [PW-1:0]               done_port
);

    import adc_scan_pkg::*;

    localparam int SW = bits_for(SETUP_CONV + 1);

    scan_state_e       state_q, state_d;
    logic [CW-1:0]     cur_q, cur_d;
    logic [NUM_CH-1:0] mask_q, mask_d;
    logic [PW-1:0]     port_q, port_d;
    logic [SW-1:0]     setup_q, setup_d;
    logic              load_list;

    logic [NUM_PORTS-1:0] arb_grant;
    logic                 arb_any;
    logic [PW-1:0]        arb_port;
    logic [NUM_CH-1:0]    arb_mask;
    logic                 needs_setup;
    logic                 first_found;
    logic [CW-1:0]        first_idx;
    logic                 next_found;
    logic [CW-1:0]        next_idx;
    logic                 run;
    logic                 slot_first;
    logic                 slot_end;
    logic [DATA_W-1:0]    data_q;

    scan_arbiter #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_CH    (NUM_CH)
    ) u_arb (
        .req_valid (req_valid),
        .req_mask  (req_mask),
        .enable    (state_q == ST_IDLE),
        .grant     (arb_grant),
        .any       (arb_any),
        .win_port  (arb_port),
        .win_mask  (arb_mask)
    );

    list_tracker #(
        .NUM_CH (NUM_CH)
    ) u_list (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_list),
        .mask        (arb_mask),
        .needs_setup (needs_setup)
    );

    // First channel of the incoming mask, and next channel of the running one.
    chan_picker #(
        .NUM_CH (NUM_CH)
    ) u_first (
        .mask     (arb_mask),
        .from_idx ('0),
        .found    (first_found),
        .idx      (first_idx)
    );

    chan_picker #(
        .NUM_CH (NUM_CH)
    ) u_next (
        .mask     (mask_q),
        .from_idx ({1'b0, cur_q} + 1'b1),
        .found    (next_found),
        .idx      (next_idx)
    );

    assign run = (state_q == ST_SETUP) || (state_q == ST_CONV);

    slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .adc_done   (adc_done),
        .slot_first (slot_first),
        .slot_end   (slot_end)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        cur_d     = cur_q;
        mask_d    = mask_q;
        port_d    = port_q;
        setup_d   = setup_q;
        load_list = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arb_any && first_found) begin
                    mask_d    = arb_mask;
                    port_d    = arb_port;
                    cur_d     = first_idx;
                    load_list = 1'b1;
                    if ((SETUP_CONV > 0) && needs_setup) begin
                        state_d = ST_SETUP;
                        setup_d = SW'(SETUP_CONV - 1);
                    end else begin
                        state_d = ST_CONV;
                    end
                end
            end
            ST_SETUP: begin
                if (slot_end) begin
                    if (setup_q == '0) begin
                        state_d = ST_CONV;
                    end else begin
                        setup_d = setup_q - 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (slot_end) begin
                    if (next_found) begin
                        cur_d = next_idx;
                    end else begin
                        state_d = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            mask_q  <= '0;
            port_q  <= '0;
            setup_q <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            mask_q  <= mask_d;
            port_q  <= port_d;
            setup_q <= setup_d;
        end
    end

    // Result capture and sample register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            smp_valid <= 1'b0;
            smp_chan  <= '0;
            smp_data  <= '0;
            smp_port  <= '0;
        end else begin
            if (adc_done) begin
                data_q <= adc_data;
            end
            smp_valid <= (state_q == ST_CONV) && slot_end;
            if ((state_q == ST_CONV) && slot_end) begin
                smp_chan <= cur_q;
                smp_data <= adc_done ? adc_data : data_q;
                smp_port <= port_q;
            end
        end
    end

    // Outputs
    always_comb begin
        req_grant   = arb_grant;
        adc_convert = slot_first;
        adc_channel = cur_q;
        scan_done   = (state_q == ST_DONE);
        done_port   = port_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            req_busy[p] = (state_q != ST_IDLE) && (port_q == PW'(p));
        end
    end

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
    parameter int NUM_CH    = 8,
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 12,
    localparam int CW       = adc_scan_pkg::bits_for(NUM_CH),
    localparam int PW       = adc_scan_pkg::bits_for(NUM_PORTS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS-1:0]        req_valid,
    input logic [NUM_PORTS*NUM_CH-1:0] req_mask,
    input logic [NUM_PORTS-1:0]        req_grant,
    input logic [NUM_PORTS-1:0]        req_busy,
    input logic                        adc_convert,
    input logic [CW-1:0]               adc_channel,
    input logic                        smp_valid,
    input logic [CW-1:0]               smp_chan,
    input logic [PW-1:0]               smp_port,
    input logic                        scan_done
);

    logic          had_smp_q;
    logic [CW-1:0] last_ch_q;

    always_ff @(posedge clk) begin
        if (!rst_n || scan_done) begin
            had_smp_q <= 1'b0;
            last_ch_q <= '0;
        end else if (smp_valid) begin
            had_smp_q <= 1'b1;
            last_ch_q <= smp_chan;
        end
    end

    // R1
    ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && had_smp_q) |-> (smp_chan > last_ch_q));

    // R2
    smp_owner_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> req_busy[smp_port]);

    // R6
    convert_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convert |-> (|req_busy));

    // R6
    convert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convert |=> !adc_convert);

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    // R7
    grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |-> !(|req_busy));

    // R7
    low_port_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant[1] |-> !(req_valid[0] && (|req_mask[NUM_CH-1:0])));

    // R8
    busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_busy));

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
            // R8
            grant_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                req_grant[gp] |=> req_busy[gp]);
            // R8
            busy_end_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(req_busy[gp]) |-> $past(scan_done));
        end
    endgenerate

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R9
    done_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> $past(smp_valid));

endmodule

bind adc_scan_seq adc_scan_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mask    (req_mask),
    .req_grant   (req_grant),
    .req_busy    (req_busy),
    .adc_convert (adc_convert),
    .adc_channel (adc_channel),
    .smp_valid   (smp_valid),
    .smp_chan    (smp_chan),
    .smp_port    (smp_port),
    .scan_done   (scan_done)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;

    localparam int SLOT = 80;
    localparam int LAT  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req_valid = '0;
    logic [15:0] req_mask = '0;
    logic [1:0]  req_grant, req_busy;
    logic        adc_convert;
    logic [2:0]  adc_channel;
    logic        adc_done;
    logic [11:0] adc_data;
    logic        smp_valid;
    logic [2:0]  smp_chan;
    logic [11:0] smp_data;
    logic [0:0]  smp_port;
    logic        scan_done;
    logic [0:0]  done_port;

    always #10 clk = ~clk;

    adc_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
        .req_grant(req_grant), .req_busy(req_busy), .adc_convert(adc_convert),
        .adc_channel(adc_channel), .adc_done(adc_done), .adc_data(adc_data),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
        .smp_port(smp_port), .scan_done(scan_done), .done_port(done_port)
    );

    // Behavioural converter: the result tags the channel and a running count.
    int         adc_cnt;
    int         adc_wait;
    logic [2:0] adc_ch_l;
    always @(posedge clk) begin
        if (!rst_n) begin
            adc_cnt <= 0; adc_wait <= 0; adc_done <= 1'b0; adc_data <= '0; adc_ch_l <= '0;
        end else begin
            adc_done <= 1'b0;
            if (adc_convert) begin
                adc_ch_l <= adc_channel;
                adc_wait <= LAT;
            end else if (adc_wait > 0) begin
                adc_wait <= adc_wait - 1;
                if (adc_wait == 1) begin
                    adc_done <= 1'b1;
                    adc_data <= {adc_ch_l, adc_cnt[8:0]};
                    adc_cnt  <= adc_cnt + 1;
                end
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int total_cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: a timeline of slots per granted scan.
    int         c;
    int         m_idle, m_g, m_S, m_ns, m_base, m_conv, m_port;
    bit         m_valid;
    logic [7:0] m_list;
    int         slot_ch [10];
    int         gr_c [2];
    int         dn_c [2];
    int         n_grant, n_conv;

    always @(negedge clk) begin : model
        int wp, k, e_end, j, n, first;
        logic [1:0] e_grant, e_busy;
        bit e_conv, e_sv, e_done;
        logic [7:0] msk;
        total_cyc++;
        if (!rst_n) begin
            c = 0; m_valid = 0; m_idle = 0; m_g = -100000; m_S = 0; m_ns = 0;
            m_conv = 0; m_port = 0; m_list = '0;
        end else begin
            e_grant = '0;
            if (c >= m_idle) begin
                wp = -1;
                for (int p = 1; p >= 0; p--)
                    if (req_valid[p] && req_mask[p*8 +: 8] != 8'h00) wp = p;
                if (wp >= 0) begin
                    e_grant[wp] = 1'b1;
                    msk  = req_mask[wp*8 +: 8];
                    m_ns = (!m_valid || msk != m_list) ? 2 : 0;
                    m_list = msk; m_valid = 1;
                    first = 0;
                    for (int ch = 7; ch >= 0; ch--) if (msk[ch]) first = ch;
                    n = 0;
                    for (int s = 0; s < m_ns; s++) begin slot_ch[n] = first; n++; end
                    for (int ch = 0; ch < 8; ch++) if (msk[ch]) begin slot_ch[n] = ch; n++; end
                    m_S = n; m_g = c; m_base = m_conv; m_conv += n; m_port = wp;
                    m_idle = c + 1 + SLOT * n + 2;
                end
            end
            k      = c - m_g - 1;
            e_end  = m_g + 1 + SLOT * m_S;
            e_busy = (c > m_g && c <= e_end + 1) ? (2'b01 << m_port) : 2'b00;
            e_conv = (k >= 0 && k < SLOT * m_S && k % SLOT == 0);
            e_sv   = 0; j = 0;
            if (k >= SLOT && k % SLOT == 0 && k / SLOT <= m_S) begin
                j = k / SLOT - 1;
                if (j >= m_ns) e_sv = 1;
            end
            e_done = (c == e_end + 1);

            chk(req_grant == e_grant, "R7", "grant", req_grant, e_grant);
            chk(req_busy == e_busy, "R8", "busy", req_busy, e_busy);
            chk(adc_convert == e_conv, "R6", "convert", adc_convert, e_conv);
            if (e_conv)
                chk(adc_channel == 3'(slot_ch[k / SLOT]), "R1", "mux channel",
                    adc_channel, slot_ch[k / SLOT]);
            chk(smp_valid == e_sv, "R3", "sample strobe", smp_valid, e_sv);
            if (e_sv && smp_valid) begin
                chk(smp_chan == 3'(slot_ch[j]), "R1", "sample channel", smp_chan, slot_ch[j]);
                chk(smp_data == {3'(slot_ch[j]), 9'(m_base + j)}, "R2", "sample data",
                    smp_data, {3'(slot_ch[j]), 9'(m_base + j)});
                chk(smp_port == 1'(m_port), "R2", "sample port", smp_port, m_port);
            end
            chk(scan_done == e_done, "R9", "done", scan_done, e_done);
            if (e_done && scan_done)
                chk(done_port == 1'(m_port), "R9", "done port", done_port, m_port);

            for (int p = 0; p < 2; p++) if (req_grant[p]) begin gr_c[p] = c; n_grant++; end
            if (scan_done) dn_c[done_port] = c;
            if (adc_convert) n_conv++;
            c++;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (total_cyc > 150000) begin
            chk(1'b0, "R8", "watchdog expired", total_cyc, 150000);
            finish_run();
        end
    end

    task automatic do_req(input int p, input logic [7:0] msk);
        @(posedge clk); #1;
        req_valid[p] = 1'b1;
        req_mask[p*8 +: 8] = msk;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); #1;
            if (req_grant[p]) break;
        end
        @(posedge clk); #1;
        req_valid[p] = 1'b0;
    endtask

    task automatic wait_done(input int p);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); #1;
            if (scan_done && done_port == 1'(p)) break;
        end
        @(posedge clk); #1;
    endtask

    task automatic run_scan(input int p, input logic [7:0] msk, input int nch,
                            input bit setup, input string tag);
        int dur, expd;
        do_req(p, msk);
        wait_done(p);
        dur  = dn_c[p] - gr_c[p];
        expd = SLOT * (nch + (setup ? 2 : 0)) + 2;
        chk(dur == expd, tag, "scan length", dur, expd);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(smp_valid == 1'b0 && scan_done == 1'b0, "R9", "reset outputs",
            {smp_valid, scan_done}, 0);
        chk(req_busy == 2'b00, "R8", "reset busy", req_busy, 0);
        chk(adc_convert == 1'b0, "R6", "reset convert", adc_convert, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        int g0, cv0;
        do_reset();
        // R3: first list after reset needs setup
        run_scan(0, 8'h0F, 4, 1'b1, "R3");
        // R4: identical list, then same list from the other port
        run_scan(0, 8'h0F, 4, 1'b0, "R4");
        run_scan(1, 8'h0F, 4, 1'b0, "R4");
        // R5: new scattered list; R1 order is checked by the model
        run_scan(0, 8'hA5, 4, 1'b1, "R5");
        // R6: full scan, second time without setup
        run_scan(0, 8'hFF, 8, 1'b1, "R5");
        run_scan(0, 8'hFF, 8, 1'b0, "R6");
        // R7: all-zero mask is ignored
        g0 = n_grant; cv0 = n_conv;
        @(posedge clk); #1;
        req_valid[1] = 1'b1; req_mask[15:8] = 8'h00;
        repeat (200) @(posedge clk);
        #1; req_valid[1] = 1'b0;
        @(negedge clk);
        chk(n_grant == g0, "R7", "zero mask grants", n_grant - g0, 0);
        chk(n_conv == cv0, "R7", "zero mask conversions", n_conv - cv0, 0);
        // R7: simultaneous requests, port 0 first
        fork
            run_scan(0, 8'h81, 2, 1'b1, "R5");
            run_scan(1, 8'h3C, 4, 1'b1, "R5");
        join
        chk(gr_c[0] < gr_c[1], "R7", "priority order", gr_c[0], gr_c[1]);
        chk(gr_c[1] == dn_c[0] + 1, "R8", "waiting grant cycle", gr_c[1], dn_c[0] + 1);
        // R8: port 0 arrives during a port 1 scan and waits
        fork
            run_scan(1, 8'h3C, 4, 1'b0, "R4");
            begin
                repeat (100) @(posedge clk);
                run_scan(0, 8'h03, 2, 1'b1, "R5");
            end
        join
        chk(gr_c[0] == dn_c[1] + 1, "R8", "no preemption", gr_c[0], dn_c[1] + 1);
        // R3: reset forgets the stored list
        do_reset();
        run_scan(0, 8'h03, 2, 1'b1, "R3");
        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule